// File: doc/BRIEF.md
# Compressed Integer Operation Executor

This unit executes a subset of 16-bit compressed instructions for a 32-bit core. Each instruction names up to two compact registers through 3-bit fields. Compact index r stands for architectural register x(8+r). A small eight-entry register file inside the top module supplies both operands. One major opcode carries three register-register ALU groups, chosen by secondary fields. A second opcode carries four small-immediate operations. Two further opcodes are branches that test the sign of the first operand.

The instruction is presented with a valid strobe, together with the PC of the instruction. The result is registered and shows up one clock later as exactly one of three outcomes: a register write (architectural index and data), a taken branch with its target, or an illegal-instruction flag. A register write also updates the internal register file at the same edge. A side load port lets the surrounding logic seed register contents, and a peek port reads any entry back.

Top module: `cx_exec`

## Requirements
- R1: After reset every output flag is low, and each of the eight compact registers reads zero on the peek port.
- R2: The opcode is taken from the instruction ANDed with 0xE003. The recognised values are 0xE000 (register-register), 0x8001 (immediate form), 0x6002 (branch if non-negative) and 0xE002 (branch if negative). Any other value raises the illegal flag.
- R3: In the register-register form, the group field is bits 12:10 and the selector is bits 6:5. The first register index is bits 9:7 and the second is bits 4:2. Group 0 with selector 0 writes first XOR second to the first register. Group 0 with selector 1 writes first shifted right arithmetically by the second. Group 0 with selector 2 or 3 is illegal.
- R4: Group 1 writes to the first register. Selector 0 gives shift left, 1 gives logical shift right, 2 gives signed less-than (result 1 or 0) and 3 gives unsigned less-than.
- R5: Group 3 performs the same four operations as group 1, but writes the result to the second register.
- R6: Register-register groups 2, 4, 5, 6 and 7 raise the illegal flag and leave the register file unchanged.
- R7: Every shift uses only bits 4:0 of the second operand as its amount.
- R8: In the immediate form, bits 12:10 form a 3-bit immediate that is sign-extended to 32 bits. Selector 0 gives ADD, 1 gives XOR, 2 gives OR and 3 gives AND, each applied to the first register and the immediate. The result goes to the second register.
- R9: A branch is taken when the first register is non-negative (0x6002) or negative (0xE002). The target is PC plus an even offset. Offset bits 4:1 come from instruction bits 6:3, offset bit 5 from bit 2, and offset bits 8:6 from bits 12:10. Bit 12 extends the sign of the offset. A branch that is not taken asserts no output.
- R10: Results appear on the cycle after the valid cycle. At most one of write, taken and illegal is high. A cycle without valid produces no output on the next cycle.
- R11: The write address output equals 8 plus the compact destination index. The written value can be read on the peek port from the next cycle on.
- R12: A load-port write stores its data in the addressed compact register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load-port write strobe |
| ld_idx | input | 3 | Load-port compact index |
| ld_data | input | 32 | Load-port data |
| in_valid | input | 1 | Instruction present |
| in_instr | input | 16 | Compressed instruction |
| in_pc | input | 32 | PC of the instruction |
| peek_idx | input | 3 | Compact index to read back |
| peek_data | output | 32 | Contents of the peeked register |
| wr_en | output | 1 | Register write performed |
| wr_addr | output | 5 | Architectural destination index |
| wr_data | output | 32 | Written value |
| br_taken | output | 1 | Branch taken |
| br_target | output | 32 | Branch target PC |
| illegal | output | 1 | Illegal instruction |

## Verification
The bench targets these corners:
- Shift amounts whose upper bits are set. A design that used the whole operand would return zero or the sign fill.
- The group 3 destination. If the write were routed to the first register, the peek compare would show stale data.
- Selectors 2 and 3 of group 0, and groups 2 and 4 to 7. These must flag illegal and must not write.
- The immediate value 111. It must act as minus one, not seven.
- Branches on zero and on the sign boundary, with negative offsets. A misplaced bit 2 or a missing sign extension gives a wrong target, and a wrong compare direction flips the taken flag.

// File: rtl/cx_pkg.sv
package cx_pkg;

    localparam int CIDX_W = 3;
    localparam int INSN_W = 16;

    localparam logic [INSN_W-1:0] OPC_MASK = 16'hE003;
    localparam logic [INSN_W-1:0] OPC_RR   = 16'hE000;
    localparam logic [INSN_W-1:0] OPC_IMM  = 16'h8001;
    localparam logic [INSN_W-1:0] OPC_BGE0 = 16'h6002;
    localparam logic [INSN_W-1:0] OPC_BLT0 = 16'hE002;

    typedef enum logic [3:0] {
        OP_ADD, OP_XOR, OP_OR, OP_AND,
        OP_SLL, OP_SRL, OP_SRA, OP_SLT, OP_SLTU
    } alu_op_e;

    typedef enum logic [1:0] {
        K_NONE, K_WRITE, K_BRANCH, K_ILLEGAL
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        alu_op_e           op;
        logic              use_imm;
        logic              br_on_neg;
        logic [CIDX_W-1:0] src1;
        logic [CIDX_W-1:0] src2;
        logic [CIDX_W-1:0] dst;
    } dec_t;

endpackage

// File: rtl/cx_decode.sv
module cx_decode
    import cx_pkg::*;
(
    input  logic [INSN_W-1:0] instr,
    output dec_t              dec
);

    logic [2:0]        grp;
    logic [1:0]        sel;
    logic [INSN_W-1:0] opc;

    assign grp = instr[12:10];
    assign sel = instr[6:5];
    assign opc = instr & OPC_MASK;

    always_comb begin
        dec           = '0;
        dec.kind      = K_ILLEGAL;
        dec.op        = OP_ADD;
        dec.src1      = instr[9:7];
        dec.src2      = instr[4:2];
        dec.dst       = instr[9:7];
        unique case (opc)
            OPC_RR: begin
                if (grp == 3'd0) begin
                    if (sel == 2'd0) begin
                        dec.kind = K_WRITE;
                        dec.op   = OP_XOR;
                    end else if (sel == 2'd1) begin
                        dec.kind = K_WRITE;
                        dec.op   = OP_SRA;
                    end
                end else if (grp == 3'd1 || grp == 3'd3) begin
                    dec.kind = K_WRITE;
                    unique case (sel)
                        2'd0: dec.op = OP_SLL;
                        2'd1: dec.op = OP_SRL;
                        2'd2: dec.op = OP_SLT;
                        default: dec.op = OP_SLTU;
                    endcase
                    if (grp == 3'd3) begin
                        dec.dst = instr[4:2];
                    end
                end
            end
            OPC_IMM: begin
                dec.kind    = K_WRITE;
                dec.use_imm = 1'b1;
                dec.dst     = instr[4:2];
                unique case (sel)
                    2'd0: dec.op = OP_ADD;
                    2'd1: dec.op = OP_XOR;
                    2'd2: dec.op = OP_OR;
                    default: dec.op = OP_AND;
                endcase
            end
            OPC_BGE0: begin
                dec.kind      = K_BRANCH;
                dec.br_on_neg = 1'b0;
            end
            OPC_BLT0: begin
                dec.kind      = K_BRANCH;
                dec.br_on_neg = 1'b1;
            end
            default: dec.kind = K_ILLEGAL;
        endcase
    end

endmodule

// File: rtl/cx_alu.sv
module cx_alu
    import cx_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);

    localparam int SHW = $clog2(XLEN);

    logic [SHW-1:0] shamt;
    assign shamt = b[SHW-1:0];

    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_XOR:  y = a ^ b;
            OP_OR:   y = a | b;
            OP_AND:  y = a & b;
            OP_SLL:  y = a << shamt;
            OP_SRL:  y = a >> shamt;
            OP_SRA:  y = XLEN'($signed(a) >>> shamt);
            OP_SLT:  y = {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
            OP_SLTU: y = {{(XLEN-1){1'b0}}, a < b};
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/cx_regfile.sv
module cx_regfile #(
    parameter int XLEN = 32,
    parameter int IW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [IW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic            ld_en,
    input  logic [IW-1:0]   ld_idx,
    input  logic [XLEN-1:0] ld_data,
    input  logic [IW-1:0]   ra1,
    input  logic [IW-1:0]   ra2,
    input  logic [IW-1:0]   ra3,
    output logic [XLEN-1:0] rd1,
    output logic [XLEN-1:0] rd2,
    output logic [XLEN-1:0] rd3
);

    localparam int DEPTH = 1 << IW;

    logic [XLEN-1:0] ent_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [XLEN-1:0] ent_d;
        always_comb begin
            ent_d = ent_q[i];
            if (we && waddr == IW'(i)) begin
                ent_d = wdata;
            end else if (ld_en && ld_idx == IW'(i)) begin
                ent_d = ld_data;
            end
        end
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[i] <= '0;
            end else begin
                ent_q[i] <= ent_d;
            end
        end
    end

    assign rd1 = ent_q[ra1];
    assign rd2 = ent_q[ra2];
    assign rd3 = ent_q[ra3];

endmodule

// File: rtl/cx_exec.sv
module cx_exec
    import cx_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int AW        = 5,
    parameter int ARCH_BASE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [CIDX_W-1:0] ld_idx,
    input  logic [XLEN-1:0]   ld_data,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] in_instr,
    input  logic [XLEN-1:0]   in_pc,
    input  logic [CIDX_W-1:0] peek_idx,
    output logic [XLEN-1:0]   peek_data,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [XLEN-1:0]   wr_data,
    output logic              br_taken,
    output logic [XLEN-1:0]   br_target,
    output logic              illegal
);

    localparam int               IMM_W = 3;
    localparam int               OFF_W = 9;
    localparam logic [AW-1:0]    BASE  = AW'(ARCH_BASE);

    typedef struct packed {
        logic            we;
        logic [AW-1:0]   wa;
        logic [XLEN-1:0] wd;
        logic            br;
        logic [XLEN-1:0] tg;
        logic            ill;
    } res_t;

    dec_t            dec;
    logic [XLEN-1:0] op_a;
    logic [XLEN-1:0] op_b;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] br_off;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y;
    logic            rf_we;
    logic            cond_ok;
    res_t            res_d;
    res_t            res_q;

    cx_decode u_dec (
        .instr (in_instr),
        .dec   (dec)
    );

    assign imm_ext = {{(XLEN-IMM_W){in_instr[12]}}, in_instr[12:10]};
    assign br_off  = {{(XLEN-OFF_W){in_instr[12]}}, in_instr[12:10],
                      in_instr[2], in_instr[6:3], 1'b0};
    assign alu_b   = dec.use_imm ? imm_ext : op_b;

    cx_alu #(.XLEN(XLEN)) u_alu (
        .op (dec.op),
        .a  (op_a),
        .b  (alu_b),
        .y  (alu_y)
    );

    assign rf_we = in_valid && (dec.kind == K_WRITE);

    cx_regfile #(.XLEN(XLEN), .IW(CIDX_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (dec.dst),
        .wdata   (alu_y),
        .ld_en   (ld_en),
        .ld_idx  (ld_idx),
        .ld_data (ld_data),
        .ra1     (dec.src1),
        .ra2     (dec.src2),
        .ra3     (peek_idx),
        .rd1     (op_a),
        .rd2     (op_b),
        .rd3     (peek_data)
    );

    assign cond_ok = dec.br_on_neg ? op_a[XLEN-1] : !op_a[XLEN-1];

    always_comb begin
        res_d = '0;
        if (in_valid) begin
            unique case (dec.kind)
                K_WRITE: begin
                    res_d.we = 1'b1;
                    res_d.wa = BASE + {{(AW-CIDX_W){1'b0}}, dec.dst};
                    res_d.wd = alu_y;
                end
                K_BRANCH: begin
                    res_d.br = cond_ok;
                    res_d.tg = cond_ok ? in_pc + br_off : '0;
                end
                K_ILLEGAL: res_d.ill = 1'b1;
                default: res_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign wr_en     = res_q.we;
    assign wr_addr   = res_q.wa;
    assign wr_data   = res_q.wd;
    assign br_taken  = res_q.br;
    assign br_target = res_q.tg;
    assign illegal   = res_q.ill;

endmodule

// File: rtl/cx_exec_chk.sv
module cx_exec_chk #(
    parameter int AW        = 5,
    parameter int ARCH_BASE = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [15:0] in_instr,
    input logic        wr_en,
    input logic [AW-1:0] wr_addr,
    input logic        br_taken,
    input logic        br_target_lsb,
    input logic        illegal
);

    logic [15:0] opc;
    logic        known_opc;
    assign opc       = in_instr & 16'hE003;
    assign known_opc = (opc == 16'hE000) || (opc == 16'h8001) ||
                       (opc == 16'h6002) || (opc == 16'hE002);

    // R10
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wr_en, br_taken, illegal}) <= 1);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!wr_en && !br_taken && !illegal));

    // R11
    dest_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr >= AW'(ARCH_BASE) && wr_addr <= AW'(ARCH_BASE + 7)));

    // R6
    bad_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opc == 16'hE000 && (in_instr[12:10] == 3'd2 || in_instr[12:10] >= 3'd4))
        |=> (illegal && !wr_en));

    // R2
    unknown_opc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !known_opc) |=> illegal);

    // R9
    even_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> !br_target_lsb);

endmodule

bind cx_exec cx_exec_chk #(.AW(AW), .ARCH_BASE(ARCH_BASE)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_instr      (in_instr),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .br_taken      (br_taken),
    .br_target_lsb (br_target[0]),
    .illegal       (illegal)
);

// File: tb/tb_cx_exec.sv
module tb_cx_exec;

    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_idx = '0;
    logic [31:0] ld_data = '0;
    logic        in_valid = 1'b0;
    logic [15:0] in_instr = '0;
    logic [31:0] in_pc = '0;
    logic [2:0]  peek_idx = '0;
    logic [31:0] peek_data;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic [31:0] wr_data;
    logic        br_taken;
    logic [31:0] br_target;
    logic        illegal;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [31:0] m [8];

    typedef struct packed {
        logic        we;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic        br;
        logic [31:0] tg;
        logic        ill;
    } exp_t;

    cx_exec dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .in_valid(in_valid), .in_instr(in_instr), .in_pc(in_pc),
        .peek_idx(peek_idx), .peek_data(peek_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .br_taken(br_taken), .br_target(br_target), .illegal(illegal)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_rr(input logic [2:0] g, input logic [1:0] s,
                                          input logic [2:0] r1, input logic [2:0] r2);
        return {3'b111, g, r1, s, r2, 2'b00};
    endfunction

    function automatic logic [15:0] mk_imm(input logic [2:0] k, input logic [1:0] s,
                                           input logic [2:0] r1, input logic [2:0] r2);
        return {3'b100, k, r1, s, r2, 2'b01};
    endfunction

    function automatic logic [15:0] mk_br(input bit neg, input logic [2:0] r1,
                                          input logic [8:0] off);
        return {neg ? 3'b111 : 3'b011, off[8:6], r1, off[4:1], off[5], 2'b10};
    endfunction

    function automatic string tag_of(input logic [15:0] ins);
        logic [15:0] o;
        o = ins & 16'hE003;
        if (o == 16'hE000) begin
            case (ins[12:10])
                3'd0: return "R3";
                3'd1: return "R4";
                3'd3: return "R5";
                default: return "R6";
            endcase
        end
        if (o == 16'h8001) return "R8";
        if (o == 16'h6002 || o == 16'hE002) return "R9";
        return "R2";
    endfunction

    function automatic int sx3(input logic [2:0] v);
        return (int'(v) ^ 4) - 4;
    endfunction

    function automatic exp_t model(input logic [15:0] ins, input logic [31:0] pc);
        exp_t e;
        logic [31:0] a, b, imm;
        logic [2:0] g, r1, r2;
        logic [1:0] s;
        logic [15:0] o;
        int off;
        e = '0;
        o = ins & 16'hE003;
        g = ins[12:10]; r1 = ins[9:7]; r2 = ins[4:2]; s = ins[6:5];
        a = m[r1]; b = m[r2];
        if (o == 16'hE000) begin
            if (g == 3'd0 && s == 2'd0) begin
                e.we = 1; e.wa = 5'(8 + r1); e.wd = a ^ b;
            end else if (g == 3'd0 && s == 2'd1) begin
                e.we = 1; e.wa = 5'(8 + r1); e.wd = 32'($signed(a) >>> b[4:0]);
            end else if (g == 3'd1 || g == 3'd3) begin
                e.we = 1;
                e.wa = 5'(8 + ((g == 3'd3) ? r2 : r1));
                case (s)
                    2'd0: e.wd = a << b[4:0];
                    2'd1: e.wd = a >> b[4:0];
                    2'd2: e.wd = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    default: e.wd = (a < b) ? 32'd1 : 32'd0;
                endcase
            end else begin
                e.ill = 1;
            end
        end else if (o == 16'h8001) begin
            imm = 32'(sx3(ins[12:10]));
            e.we = 1; e.wa = 5'(8 + r2);
            case (s)
                2'd0: e.wd = a + imm;
                2'd1: e.wd = a ^ imm;
                2'd2: e.wd = a | imm;
                default: e.wd = a & imm;
            endcase
        end else if (o == 16'h6002 || o == 16'hE002) begin
            off = int'(ins[6:3]) * 2 + int'(ins[2]) * 32 + sx3(ins[12:10]) * 64;
            e.br = (o == 16'hE002) ? (a[31] == 1'b1) : (a[31] == 1'b0);
            if (e.br) e.tg = pc + 32'(off);
        end else begin
            e.ill = 1;
        end
        return e;
    endfunction

    task automatic load(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        ld_en = 1; ld_idx = idx; ld_data = d;
        @(negedge clk);
        ld_en = 0;
        m[idx] = d;
    endtask

    task automatic run(input logic [15:0] ins, input logic [31:0] pc);
        exp_t e;
        string t;
        e = model(ins, pc);
        t = tag_of(ins);
        @(negedge clk);
        in_valid = 1; in_instr = ins; in_pc = pc;
        @(negedge clk);
        in_valid = 0;
        chk(wr_en == e.we, t, "wr_en", 32'(wr_en), 32'(e.we));
        if (e.we) begin
            chk(wr_addr == e.wa, "R11", "wr_addr", 32'(wr_addr), 32'(e.wa));
            chk(wr_data == e.wd, t, "wr_data", wr_data, e.wd);
            m[e.wa - 5'd8] = e.wd;
        end
        chk(br_taken == e.br, t, "br_taken", 32'(br_taken), 32'(e.br));
        if (e.br) chk(br_target == e.tg, t, "br_target", br_target, e.tg);
        chk(illegal == e.ill, t, "illegal", 32'(illegal), 32'(e.ill));
    endtask

    task automatic peek_all(input string t);
        for (int i = 0; i < 8; i++) begin
            peek_idx = 3'(i);
            #1;
            chk(peek_data == m[i], t, "peek", peek_data, m[i]);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 8; i++) m[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!wr_en && !br_taken && !illegal, "R1", "flags", {29'd0, wr_en, br_taken, illegal}, 32'd0);
        peek_all("R1");

        // R12 load port
        load(3'd0, 32'h8000_0001);
        load(3'd1, 32'hFFFF_FFE4);
        load(3'd2, 32'h0000_0007);
        load(3'd3, 32'h1234_5678);
        load(3'd4, 32'hFFFF_FFFF);
        load(3'd5, 32'h0000_0000);
        peek_all("R12");

        // R3 / R7: xor, sra with amount 0xFFFFFFE4 -> 4
        run(mk_rr(3'd0, 2'd0, 3'd3, 3'd2), 32'h100);
        run(mk_rr(3'd0, 2'd1, 3'd0, 3'd1), 32'h100);
        run(mk_rr(3'd0, 2'd2, 3'd0, 3'd1), 32'h100);
        run(mk_rr(3'd0, 2'd3, 3'd0, 3'd1), 32'h100);
        // R4 / R7
        load(3'd0, 32'h8000_0001);
        run(mk_rr(3'd1, 2'd0, 3'd3, 3'd1), 32'h0);
        run(mk_rr(3'd1, 2'd1, 3'd0, 3'd1), 32'h0);
        run(mk_rr(3'd1, 2'd2, 3'd4, 3'd2), 32'h0);
        run(mk_rr(3'd1, 2'd3, 3'd4, 3'd2), 32'h0);
        // R5 destination is the second register
        run(mk_rr(3'd3, 2'd2, 3'd4, 3'd6), 32'h0);
        run(mk_rr(3'd3, 2'd0, 3'd2, 3'd7), 32'h0);
        peek_all("R5");
        // R6 illegal groups leave registers alone
        for (int g = 2; g < 8; g++) begin
            if (g != 3) run(mk_rr(3'(g), 2'd0, 3'd2, 3'd3), 32'h0);
        end
        peek_all("R6");
        // R8 immediate -1 and +3
        run(mk_imm(3'b111, 2'd0, 3'd5, 3'd6), 32'h0);
        run(mk_imm(3'b111, 2'd3, 3'd3, 3'd7), 32'h0);
        run(mk_imm(3'b011, 2'd2, 3'd5, 3'd1), 32'h0);
        run(mk_imm(3'b100, 2'd1, 3'd2, 3'd2), 32'h0);
        peek_all("R8");
        // R9 branches
        load(3'd5, 32'h0);
        run(mk_br(1'b0, 3'd5, 9'h020), 32'h0000_1000);
        run(mk_br(1'b1, 3'd5, 9'h020), 32'h0000_1000);
        run(mk_br(1'b1, 3'd4, 9'h1FE), 32'h0000_1000);
        run(mk_br(1'b0, 3'd4, 9'h1FE), 32'h0000_1000);
        run(mk_br(1'b0, 3'd3, 9'h100), 32'h0000_2000);
        run(mk_br(1'b1, 3'd0, 9'h0FE), 32'h0000_0004);
        // R2 unknown opcodes
        run(16'h0001, 32'h0);
        run(16'h8000, 32'h0);
        run(16'h4002, 32'h0);
        // R10 idle cycle
        @(negedge clk);
        chk(!wr_en && !br_taken && !illegal, "R10", "idle", {29'd0, wr_en, br_taken, illegal}, 32'd0);

        // random mix (R3..R9, R11)
        for (int n = 0; n < 3000; n++) begin
            int k;
            logic [15:0] ins;
            if (n % 16 == 0) begin
                logic [31:0] v;
                v = $urandom();
                if ($urandom() % 4 == 0) v = {v[31], 31'($urandom() % 40)};
                load(3'($urandom()), v);
            end
            k = int'($urandom() % 10);
            ins = 16'($urandom());
            if (k < 4)      ins = {3'b111, ins[12:2], 2'b00};
            else if (k < 6) ins = {3'b100, ins[12:2], 2'b01};
            else if (k < 8) ins = {3'b011, ins[12:2], 2'b10};
            else if (k < 9) ins = {3'b111, ins[12:2], 2'b10};
            run(ins, {$urandom()} & 32'hFFFF_FFFE);
            if (n % 200 == 0) peek_all("R11");
        end
        peek_all("R11");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R10 watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule